// File: doc/BRIEF.md
# Fractional PLL Frequency Calculator

This block works out the output frequency of a fractional-N synthesizer from the synthesizer's 32-bit control word and a 32-bit reference frequency in hertz. The control word carries four fields: a pre-divider, a fraction denominator, an integer multiplier and a signed fraction numerator. The block decodes these fields and applies the offset, floor and sign rules. It then evaluates

    freq = ((2 * (ref >> 10) * (int * den + num)) / (den * prediv)) << 10

All intermediate values are held at 64 bits, and the division truncates.

The caller presents a control word and a reference, and pulses `start` while the block is idle. A non-negative numerator term sends a 64-bit dividend to a restoring divider that produces one quotient bit per cycle. A negative term skips the divider: the block reports zero and raises an error flag at once. In both cases `done` marks the cycle in which `freq_out` and `neg_err` take the new result. Those two outputs hold their values until the next completion.

Top module: `fpll_freq_calc`

## Requirements
- R1: The control word fields are bits 29:26 (pre-divider), 25:16 (denominator), 13:10 (integer multiplier) and 9:0 (numerator). The effective pre-divider and the effective denominator are each the field value plus one.
- R2: An integer multiplier field below 5 gives the same result as a field of exactly 5.
- R3: The numerator field is a 10-bit two's-complement number, so a field with bit 9 set counts as the field value minus 1024.
- R4: For a non-negative term, `freq_out` equals 2 × (ref >> 10) × term, divided by (denominator × pre-divider) with truncation and then shifted left by 10. The result is cut to 32 bits, so its low 10 bits are always zero.
- R5: When int × den + num is negative, the block reports `freq_out` = 0 with `neg_err` = 1. `done` rises on the clock edge that accepts `start`.
- R6: For a non-negative term, `done` rises on the 65th clock edge after the accepting edge (dividend width plus one), and `neg_err` is 0.
- R7: `done` is high for exactly one cycle per accepted request. `busy` is high from the accepting edge through the cycle in which `done` is high.
- R8: A `start` that arrives while `busy` is high is ignored. It produces no extra `done`, and the result reflects the request that was accepted.
- R9: After reset `freq_out`, `neg_err`, `done` and `busy` are 0. Between completions, `freq_out` and `neg_err` keep their values whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a calculation (accepted only when idle) |
| ctrl_word | input | 32 | Synthesizer control word, sampled on the accepting edge |
| ref_freq | input | 32 | Reference frequency in Hz, sampled on the accepting edge |
| busy | output | 1 | Calculation in progress or result cycle |
| done | output | 1 | One-cycle pulse: result valid |
| freq_out | output | 32 | Computed output frequency in Hz |
| neg_err | output | 1 | Last result came from a negative numerator term |

## Verification
Damage to the divider's shift or remainder state shows up as a wrong `freq_out` at the single `done` pulse, 65 edges after acceptance. Damage to its bit counter shows up as `done` arriving early, arriving late, or never arriving. Errors in field decoding or in the sign rule show up at that same pulse, as a wrong value or a wrong `neg_err`. An error in the negative path already shows on the accepting edge. Broken busy gating appears as a second `done` pulse, or as a result taken from the ignored request, within one divide time.

// File: rtl/fpll_pkg.sv
package fpll_pkg;

  // Control word field positions (decoded by the arithmetic below)
  localparam int PREDIV_LSB = 26;
  localparam int PREDIV_W   = 4;
  localparam int DEN_LSB    = 16;
  localparam int DEN_W      = 10;
  localparam int MULT_LSB   = 10;
  localparam int MULT_W     = 4;
  localparam int NUM_LSB    = 0;
  localparam int NUM_W      = 10;
  localparam int MULT_FLOOR = 5;

  typedef struct packed {
    logic [PREDIV_W:0]        prediv_eff;  // 1 .. 16
    logic [DEN_W:0]           den_eff;     // 1 .. 1024
    logic [MULT_W-1:0]        mult_eff;    // 5 .. 15
    logic signed [NUM_W-1:0]  num_s;       // -512 .. 511
  } fpll_fields_t;

  function automatic fpll_fields_t f_unpack(input logic [31:0] w);
    fpll_fields_t f;
    logic [MULT_W-1:0] m;
    f.prediv_eff = {1'b0, w[PREDIV_LSB +: PREDIV_W]} + 1'b1;
    f.den_eff    = {1'b0, w[DEN_LSB +: DEN_W]} + 1'b1;
    m            = w[MULT_LSB +: MULT_W];
    f.mult_eff   = (int'(m) < MULT_FLOOR) ? MULT_W'(MULT_FLOOR) : m;
    f.num_s      = $signed(w[NUM_LSB +: NUM_W]);
    return f;
  endfunction

  // Signed numerator term: mult * den + num
  function automatic int f_term(input fpll_fields_t f);
    int a;
    int b;
    int c;
    a = int'(f.mult_eff);
    b = int'(f.den_eff);
    c = int'(f.num_s);
    return a * b + c;
  endfunction

  // Divisor: den * prediv, at most 16384
  function automatic int f_divisor(input fpll_fields_t f);
    return int'(f.den_eff) * int'(f.prediv_eff);
  endfunction

endpackage

// File: rtl/fpll_field_unpack.sv
module fpll_field_unpack
  import fpll_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] ctrl_word,
  output fpll_fields_t      fields
);
  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^{ctrl_word[DATA_W-1:PREDIV_LSB+PREDIV_W],
                              ctrl_word[DEN_LSB-1:MULT_LSB+MULT_W]};
  assign fields = f_unpack(ctrl_word[31:0]);

  always_comb begin
    AST_MULT_FLOOR: assert (int'(fields.mult_eff) >= MULT_FLOOR || $isunknown(ctrl_word)); // R2
  end
endmodule

// File: rtl/fpll_operand_build.sv
module fpll_operand_build
  import fpll_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PROD_W    = 64,
  parameter int DIV_W     = 16,
  parameter int REF_SHIFT = 10
) (
  input  fpll_fields_t       fields,
  input  logic [DATA_W-1:0]  ref_freq,
  output logic [PROD_W-1:0]  dividend,
  output logic [DIV_W-1:0]   divisor,
  output logic               term_neg
);
  int                 term_s;
  logic [PROD_W-1:0]  ref_scaled;
  logic [PROD_W-1:0]  term_mag;
  logic [PROD_W-1:0]  product;
  logic               unused_ref_low;

  assign unused_ref_low = ^ref_freq[REF_SHIFT-1:0];
  assign term_s     = f_term(fields);
  assign term_neg   = term_s < 0;
  assign ref_scaled = PROD_W'(ref_freq[DATA_W-1:REF_SHIFT]);
  assign term_mag   = term_neg ? '0 : PROD_W'(term_s[30:0]);
  assign product    = ref_scaled * term_mag;
  assign dividend   = product << 1;
  assign divisor    = DIV_W'(f_divisor(fields));

  always_comb begin
    AST_DIVISOR_NONZERO: assert (divisor != '0 || $isunknown(fields)); // R1
  end
endmodule

// File: rtl/fpll_restoring_div.sv
module fpll_restoring_div #(
  parameter int N_W = 64,
  parameter int D_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic           busy,
  output logic           fin,
  output logic [N_W-1:0] quotient
);
  localparam int CNT_W = $clog2(N_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [D_W-1:0]   rem;
  logic [D_W-1:0]   dsr;
  logic [N_W-1:0]   qsh;
  logic [D_W:0]     rem_shift;
  logic [D_W:0]     rem_diff;
  logic             fits;
  logic             last_step;
  logic             unused_diff_msb;

  assign rem_shift = {rem, qsh[N_W-1]};
  assign fits      = rem_shift >= {1'b0, dsr};
  assign rem_diff  = fits ? (rem_shift - {1'b0, dsr}) : rem_shift;
  assign unused_diff_msb = rem_diff[D_W];
  assign last_step = busy && (cnt == CNT_W'(1));
  assign quotient  = qsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      fin  <= 1'b0;
      cnt  <= '0;
      rem  <= '0;
      dsr  <= '0;
      qsh  <= '0;
    end else begin
      fin <= 1'b0;
      if (busy) begin
        rem <= rem_diff[D_W-1:0];
        qsh <= {qsh[N_W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (last_step) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end else if (go) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(N_W);
        rem  <= '0;
        dsr  <= divisor;
        qsh  <= dividend;
      end
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem < dsr)); // R4
  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy); // R8
  AST_FIN_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin) |-> $fell(busy)); // R6
endmodule

// File: rtl/fpll_freq_calc.sv
module fpll_freq_calc
  import fpll_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PROD_W    = 64,
  parameter int DIV_W     = 16,
  parameter int REF_SHIFT = 10,
  parameter int OUT_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] ctrl_word,
  input  logic [DATA_W-1:0] ref_freq,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] freq_out,
  output logic              neg_err
);
  localparam int KEEP_W = DATA_W - OUT_SHIFT;

  fpll_fields_t       fields;
  logic [PROD_W-1:0]  dividend;
  logic [DIV_W-1:0]   divisor;
  logic               term_neg;
  logic               accept;
  logic               div_go;
  logic               div_busy;
  logic               div_fin;
  logic [PROD_W-1:0]  quotient;
  logic [DATA_W-1:0]  result_w;
  logic               unused_quo_high;

  fpll_field_unpack #(.DATA_W(DATA_W)) u_unpack (
    .ctrl_word (ctrl_word),
    .fields    (fields)
  );

  fpll_operand_build #(
    .DATA_W(DATA_W), .PROD_W(PROD_W), .DIV_W(DIV_W), .REF_SHIFT(REF_SHIFT)
  ) u_operands (
    .fields   (fields),
    .ref_freq (ref_freq),
    .dividend (dividend),
    .divisor  (divisor),
    .term_neg (term_neg)
  );

  assign busy   = div_busy | div_fin | done;
  assign accept = start && !busy;
  assign div_go = accept && !term_neg;

  fpll_restoring_div #(.N_W(PROD_W), .D_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (dividend),
    .divisor  (divisor),
    .busy     (div_busy),
    .fin      (div_fin),
    .quotient (quotient)
  );

  assign unused_quo_high = ^quotient[PROD_W-1:KEEP_W];
  assign result_w = {quotient[KEEP_W-1:0], {OUT_SHIFT{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      freq_out <= '0;
      neg_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept && term_neg) begin
        freq_out <= '0;
        neg_err  <= 1'b1;
        done     <= 1'b1;
      end else if (div_fin) begin
        freq_out <= result_w;
        neg_err  <= 1'b0;
        done     <= 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done)); // R7
  AST_NEG_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && neg_err) |-> (freq_out == '0)); // R5
  AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (freq_out[OUT_SHIFT-1:0] == '0)); // R4
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(freq_out) && $stable(neg_err))); // R9
endmodule

// File: tb/fpll_freq_calc_test.sv
`timescale 1ns/1ps
module fpll_freq_calc_test;
  localparam int LAT_OK = 65;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic [31:0] ref_freq = '0;
  logic        busy;
  logic        done;
  logic [31:0] freq_out;
  logic        neg_err;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fpll_freq_calc uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(ctrl_word),
    .ref_freq(ref_freq), .busy(busy), .done(done), .freq_out(freq_out),
    .neg_err(neg_err)
  );

  function automatic logic [31:0] mkword(input int pre, input int den,
                                         input int mul, input int num);
    logic [31:0] w;
    w = '0;
    w[29:26] = 4'(pre);
    w[25:16] = 10'(den);
    w[13:10] = 4'(mul);
    w[9:0]   = 10'(num);
    return w;
  endfunction

  task automatic model(input logic [31:0] w, input logic [31:0] r,
                       output logic [31:0] f, output logic e);
    longint pre, den, mul, num, term, q;
    pre = longint'(w[29:26]) + 1;
    den = longint'(w[25:16]) + 1;
    mul = longint'(w[13:10]);
    if (mul < 5) mul = 5;
    num = longint'(w[9:0]);
    if (w[9]) num = num - 1024;
    term = mul * den + num;
    if (term < 0) begin
      f = '0; e = 1'b1;
    end else begin
      q = (2 * longint'(r >> 10) * term) / (den * pre);
      f = 32'(q * 1024); e = 1'b0;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic [31:0] r,
                     output logic [31:0] f, output logic e, output int lat);
    @(negedge clk);
    ctrl_word = w; ref_freq = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    f = freq_out; e = neg_err;
  endtask

  task automatic run_and_check(input string req, input logic [31:0] w, input logic [31:0] r);
    logic [31:0] f, ef;
    logic e, ee;
    int lat;
    model(w, r, ef, ee);
    run(w, r, f, e, lat);
    chk(req, f, ef);
    chk(req, 32'(e), 32'(ee));
    chk(req, 32'(lat), ee ? 32'd0 : 32'(LAT_OK));
  endtask

  task automatic t_reset();
    chk("R9 reset freq_out", freq_out, 32'd0);
    chk("R9 reset done", 32'(done), 32'd0);
    chk("R9 reset busy", 32'(busy), 32'd0);
    chk("R9 reset neg_err", 32'(neg_err), 32'd0);
  endtask

  task automatic t_basic();
    logic [31:0] f; logic e; int lat;
    run(mkword(1, 0, 6, 0), 32'd26000000, f, e, lat);
    chk("R1 R4 basic value", f, 32'd155996160);
    chk("R6 basic latency", 32'(lat), 32'(LAT_OK));
    chk("R6 basic neg_err", 32'(e), 32'd0);
    @(negedge clk);
    chk("R7 done drops", 32'(done), 32'd0);
    chk("R7 busy drops", 32'(busy), 32'd0);
    run_and_check("R1 fields den4 mul12 num1", mkword(1, 4, 12, 1), 32'd26000000);
    run_and_check("R1 prediv15 den1023", mkword(15, 1023, 9, 300), 32'd33554432);
  endtask

  task automatic t_busy_flag();
    @(negedge clk);
    ctrl_word = mkword(0, 2, 7, 0); ref_freq = 32'd12000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 busy after accept", 32'(busy), 32'd1);
    while (!done) @(negedge clk);
    chk("R7 busy during done", 32'(busy), 32'd1);
    @(negedge clk);
  endtask

  task automatic t_floor();
    logic [31:0] f0, f5; logic e; int lat;
    run(mkword(0, 3, 0, 0), 32'd19200000, f0, e, lat);
    run(mkword(0, 3, 5, 0), 32'd19200000, f5, e, lat);
    chk("R2 mult 0 equals mult 5", f0, f5);
    run_and_check("R2 mult 3 model", mkword(2, 7, 3, 5), 32'd26000000);
  endtask

  task automatic t_sign();
    logic [31:0] fn, fp; logic e; int lat;
    run(mkword(0, 9, 8, 10'h3FF), 32'd26000000, fn, e, lat);
    run(mkword(0, 9, 8, 0), 32'd26000000, fp, e, lat);
    chk("R3 num -1 below num 0", 32'(fn < fp), 32'd1);
    run_and_check("R3 num -1 model", mkword(0, 9, 8, 10'h3FF), 32'd26000000);
    run_and_check("R3 num -300 model", mkword(3, 99, 4, 10'h2D4), 32'd26000000);
  endtask

  task automatic t_negative();
    run_and_check("R6 set good result", mkword(0, 0, 10, 0), 32'd26000000);
    run_and_check("R5 negative term", mkword(0, 0, 5, 10'h200), 32'd26000000);
    run_and_check("R5 zero term no error", mkword(0, 4, 5, 10'h3E7), 32'd26000000);
  endtask

  task automatic t_overflow();
    run_and_check("R4 32-bit truncation", mkword(0, 1023, 15, 511), 32'hFFFFFFFF);
    run_and_check("R4 small ref", mkword(0, 0, 6, 0), 32'd1023);
  endtask

  task automatic t_random();
    for (int i = 0; i < 12; i++) begin
      run_and_check("R4 random word", $urandom(), $urandom());
    end
  endtask

  task automatic t_busy_ignore();
    logic [31:0] ef; logic ee; int dones;
    model(mkword(1, 0, 6, 0), 32'd26000000, ef, ee);
    @(negedge clk);
    ctrl_word = mkword(1, 0, 6, 0); ref_freq = 32'd26000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    ctrl_word = mkword(0, 0, 15, 0); ref_freq = 32'd50000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dones = 0;
    for (int c = 0; c < 150; c++) begin
      if (done) begin
        dones++;
        if (dones == 1) chk("R8 first request result", freq_out, ef);
      end
      @(negedge clk);
    end
    chk("R8 one done only", 32'(dones), 32'd1);
  endtask

  task automatic t_hold();
    logic [31:0] held; logic heldn; int dn;
    run_and_check("R9 prepare", mkword(2, 5, 11, 17), 32'd24000000);
    held = freq_out; heldn = neg_err; dn = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      ctrl_word = $urandom(); ref_freq = $urandom();
      if (done) dn++;
    end
    chk("R9 freq_out holds", freq_out, held);
    chk("R9 neg_err holds", 32'(neg_err), 32'(heldn));
    chk("R9 no done without start", 32'(dn), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_busy_flag();
    t_floor();
    t_sign();
    t_negative();
    t_overflow();
    t_random();
    t_busy_ignore();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule